// File: doc/BRIEF.md
# Channel-Addressed Serial Register Bank

This block is the write-side register interface for a four-channel frequency synthesizer. A host sends serial write transactions. Each frame, bounded by an active-low chip select, starts with one address byte and continues with data bytes. The bank routes each per-channel word to every channel enabled in a channel-select mask. The frequency and phase words, and a global control word, first go into a pending copy.

The active copy, which drives the synthesizer core, changes only when the host raises a shared update line. Every pending value then moves across in the same clock cycle. This lets a host change the frequency on all channels and keep their relative phase offsets. It can stage any mix of words and then apply them as one atomic change.

The serial pins and the update line are sampled by the core clock through synchronizers, so the serial clock may be fully asynchronous to the core.

Top module: `chan_reg_bank`

## Requirements
- R1: After reset, every active frequency word, every active phase word and both control outputs are zero, and the channel-select mask enables all four channels.
- R2: Serial data uses mode 0. `mosi` is sampled on each rising `sck` edge while `cs_n` is low, most significant bit first. The first byte of a frame is the register address.
- R3: Address 0x04 takes a 32-bit frequency word as four data bytes, most significant byte first.
- R4: Address 0x05 takes two data bytes, most significant first. The phase word is the low 14 bits of that 16-bit value, and the top two bits are ignored.
- R5: Address 0x00 takes one byte that sets the channel-select mask. Bit 4 enables channel 0, bit 5 channel 1, bit 6 channel 2 and bit 7 channel 3. A frequency or phase write updates the pending word of every channel enabled at that time and leaves the others untouched.
- R6: Active words never change except on a commit. A rising edge of `io_update` commits all pending words together. The active outputs change at the third rising `clk` edge after `io_update` rises. Holding `io_update` high produces no further commit.
- R7: Address 0x03 takes a 24-bit control word as three bytes, most significant first, and it is double buffered like the channel words. Bit 13 of the active word drives `autoclear_o` and bit 12 drives `clear_acc_o`.
- R8: Data bytes beyond the width of the addressed register are ignored. A frame whose address is none of 0x00, 0x03, 0x04 or 0x05 changes nothing.
- R9: If `cs_n` rises before a word is complete, the partial word is discarded and no pending register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| io_update | input | 1 | Commit request; its rising edge applies all pending words |
| freq_words_o | output | NCH*FTW_W | Active frequency words, channel 0 in the low bits |
| phase_words_o | output | NCH*POW_W | Active phase words, channel 0 in the low bits |
| autoclear_o | output | 1 | Active control bit 13 |
| clear_acc_o | output | 1 | Active control bit 12 |

## Verification
The assertions rely on `sck` being slow compared with `clk`. Each level must be held for several core cycles, so that every serial edge is seen once after synchronization. They also rely on `cs_n` staying low for a few cycles after the last serial edge of a frame.

The bench holds each `sck` phase for eight core cycles. It keeps `cs_n` steady for six cycles around each frame. It raises `io_update` only while no frame is in flight.

A behavioural model tracks the pending and active words for every channel. It is checked on every clock. Its commit is timed from `io_update` samples, so both the three-edge latency and the level-hold case are checked.

// File: rtl/crb_pkg.sv
package crb_pkg;
   localparam logic [7:0] ADR_CHSEL = 8'h00;
   localparam logic [7:0] ADR_CTRL  = 8'h03;
   localparam logic [7:0] ADR_FREQ  = 8'h04;
   localparam logic [7:0] ADR_PHASE = 8'h05;
   localparam int         WORD_MAX  = 32;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_CHSEL,
      TGT_CTRL,
      TGT_FREQ,
      TGT_PHASE
   } tgt_e;

   function automatic int byte_len(input int bits);
      return (bits + 7) / 8;
   endfunction
endpackage

// File: rtl/crb_sync.sv
module crb_sync #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("crb_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/crb_deframer.sv
module crb_deframer (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_s,
   input  logic       cs_n_s,
   input  logic       mosi_s,
   output logic       byte_vld,
   output logic [7:0] byte_q
);
   logic       sck_d;
   logic [2:0] bit_cnt;
   logic [6:0] shift_q;
   logic       sck_rise;

   assign sck_rise = sck_s & ~sck_d & ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         bit_cnt  <= '0;
         shift_q  <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         sck_d    <= sck_s;
         byte_vld <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            shift_q <= {shift_q[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_vld <= 1'b1;
               byte_q   <= {shift_q, mosi_s};
            end
         end
      end
   end
endmodule

// File: rtl/crb_decoder.sv
module crb_decoder
   import crb_pkg::*;
#(
   parameter int FTW_W  = 32,
   parameter int POW_W  = 14,
   parameter int CTRL_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n_s,
   input  logic                byte_vld,
   input  logic [7:0]          byte_q,
   output logic                wr_chsel,
   output logic                wr_ctrl,
   output logic                wr_freq,
   output logic                wr_phase,
   output logic [WORD_MAX-1:0] wr_data
);
   localparam logic [2:0] FREQ_BYTES  = 3'(byte_len(FTW_W));
   localparam logic [2:0] PHASE_BYTES = 3'(byte_len(POW_W));
   localparam logic [2:0] CTRL_BYTES  = 3'(byte_len(CTRL_W));

   logic                have_addr;
   tgt_e                tgt;
   logic [2:0]          need;
   logic [2:0]          got;
   logic [WORD_MAX-9:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_addr <= 1'b0;
         tgt       <= TGT_NONE;
         need      <= '0;
         got       <= '0;
         acc       <= '0;
         wr_chsel  <= 1'b0;
         wr_ctrl   <= 1'b0;
         wr_freq   <= 1'b0;
         wr_phase  <= 1'b0;
         wr_data   <= '0;
      end else begin
         wr_chsel <= 1'b0;
         wr_ctrl  <= 1'b0;
         wr_freq  <= 1'b0;
         wr_phase <= 1'b0;
         if (cs_n_s) begin
            have_addr <= 1'b0;
            got       <= '0;
         end else if (byte_vld) begin
            if (!have_addr) begin
               have_addr <= 1'b1;
               got       <= '0;
               acc       <= '0;
               unique case (byte_q)
                  ADR_CHSEL: begin tgt <= TGT_CHSEL; need <= 3'd1;        end
                  ADR_CTRL:  begin tgt <= TGT_CTRL;  need <= CTRL_BYTES;  end
                  ADR_FREQ:  begin tgt <= TGT_FREQ;  need <= FREQ_BYTES;  end
                  ADR_PHASE: begin tgt <= TGT_PHASE; need <= PHASE_BYTES; end
                  default:   begin tgt <= TGT_NONE;  need <= 3'd0;        end
               endcase
            end else if (got < need) begin
               acc <= {acc[WORD_MAX-17:0], byte_q};
               got <= got + 3'd1;
               if (got + 3'd1 == need) begin
                  wr_data <= {acc, byte_q};
                  case (tgt)
                     TGT_CHSEL: wr_chsel <= 1'b1;
                     TGT_CTRL:  wr_ctrl  <= 1'b1;
                     TGT_FREQ:  wr_freq  <= 1'b1;
                     TGT_PHASE: wr_phase <= 1'b1;
                     default:   ;
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/crb_chan_bank.sv
module crb_chan_bank
   import crb_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int FTW_W  = 32,
   parameter int POW_W  = 14,
   parameter int CTRL_W = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_chsel,
   input  logic                 wr_ctrl,
   input  logic                 wr_freq,
   input  logic                 wr_phase,
   input  logic [WORD_MAX-1:0]  wr_data,
   input  logic                 commit,
   output logic [NCH*FTW_W-1:0] freq_words,
   output logic [NCH*POW_W-1:0] phase_words,
   output logic [CTRL_W-1:0]    ctrl_word
);
   logic [3:0]        chan_en;
   logic [CTRL_W-1:0] ctrl_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_en   <= 4'hF;
         ctrl_pend <= '0;
         ctrl_word <= '0;
      end else begin
         if (wr_chsel) chan_en   <= wr_data[7:4];
         if (wr_ctrl)  ctrl_pend <= wr_data[CTRL_W-1:0];
         if (commit)   ctrl_word <= ctrl_pend;
      end
   end

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         logic [FTW_W-1:0] f_pend, f_act;
         logic [POW_W-1:0] p_pend, p_act;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f_pend <= '0;
               p_pend <= '0;
               f_act  <= '0;
               p_act  <= '0;
            end else begin
               if (wr_freq && chan_en[ch])  f_pend <= wr_data[FTW_W-1:0];
               if (wr_phase && chan_en[ch]) p_pend <= wr_data[POW_W-1:0];
               if (commit) begin
                  f_act <= f_pend;
                  p_act <= p_pend;
               end
            end
         end

         assign freq_words[ch*FTW_W +: FTW_W]  = f_act;
         assign phase_words[ch*POW_W +: POW_W] = p_act;
      end
   endgenerate
endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank
   import crb_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int FTW_W       = 32,
   parameter int POW_W       = 14,
   parameter int CTRL_W      = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sck,
   input  logic                 cs_n,
   input  logic                 mosi,
   input  logic                 io_update,
   output logic [NCH*FTW_W-1:0] freq_words_o,
   output logic [NCH*POW_W-1:0] phase_words_o,
   output logic                 autoclear_o,
   output logic                 clear_acc_o
);
   localparam int AUTOCLR_BIT = 13;
   localparam int CLRACC_BIT  = 12;

   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("NCH must be 1..4");
      end
      if (FTW_W > WORD_MAX || POW_W > 16 || CTRL_W > WORD_MAX) begin : g_bad_w
         $error("register width out of range");
      end
      if (CTRL_W <= AUTOCLR_BIT) begin : g_bad_ctrl
         $error("control word too narrow");
      end
   endgenerate

   logic                sck_s, cs_n_s, mosi_s, upd_s, upd_d, commit;
   logic                byte_vld;
   logic [7:0]          byte_q;
   logic                wr_chsel, wr_ctrl, wr_freq, wr_phase;
   logic [WORD_MAX-1:0] wr_data;
   logic [CTRL_W-1:0]   ctrl_word;

   crb_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0100)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck, cs_n, mosi, io_update}),
      .q     ({sck_s, cs_n_s, mosi_s, upd_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_d <= 1'b0;
      else        upd_d <= upd_s;
   end
   assign commit = upd_s & ~upd_d;

   crb_deframer i_deframer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (sck_s),
      .cs_n_s   (cs_n_s),
      .mosi_s   (mosi_s),
      .byte_vld (byte_vld),
      .byte_q   (byte_q)
   );

   crb_decoder #(.FTW_W(FTW_W), .POW_W(POW_W), .CTRL_W(CTRL_W)) i_decoder (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_s   (cs_n_s),
      .byte_vld (byte_vld),
      .byte_q   (byte_q),
      .wr_chsel (wr_chsel),
      .wr_ctrl  (wr_ctrl),
      .wr_freq  (wr_freq),
      .wr_phase (wr_phase),
      .wr_data  (wr_data)
   );

   crb_chan_bank #(.NCH(NCH), .FTW_W(FTW_W), .POW_W(POW_W), .CTRL_W(CTRL_W)) i_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_chsel    (wr_chsel),
      .wr_ctrl     (wr_ctrl),
      .wr_freq     (wr_freq),
      .wr_phase    (wr_phase),
      .wr_data     (wr_data),
      .commit      (commit),
      .freq_words  (freq_words_o),
      .phase_words (phase_words_o),
      .ctrl_word   (ctrl_word)
   );

   assign autoclear_o = ctrl_word[AUTOCLR_BIT];
   assign clear_acc_o = ctrl_word[CLRACC_BIT];
endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
   parameter int FW = 128,
   parameter int PW = 56
) (
   input logic          clk,
   input logic          rst_n,
   input logic          commit,
   input logic          cs_n_s,
   input logic          byte_vld,
   input logic          wr_chsel,
   input logic          wr_ctrl,
   input logic          wr_freq,
   input logic          wr_phase,
   input logic [FW-1:0] freq_words_o,
   input logic [PW-1:0] phase_words_o,
   input logic          autoclear_o,
   input logic          clear_acc_o
);
   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable({freq_words_o, phase_words_o})); // R6
   AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit); // R6
   AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> !cs_n_s); // R2
   AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_chsel, wr_ctrl, wr_freq, wr_phase})); // R8
   AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |-> !(wr_chsel | wr_ctrl | wr_freq | wr_phase)); // R9
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable({autoclear_o, clear_acc_o})); // R7
endmodule

bind chan_reg_bank crb_checker #(.FW(NCH*FTW_W), .PW(NCH*POW_W)) i_crb_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .commit        (commit),
   .cs_n_s        (cs_n_s),
   .byte_vld      (byte_vld),
   .wr_chsel      (wr_chsel),
   .wr_ctrl       (wr_ctrl),
   .wr_freq       (wr_freq),
   .wr_phase      (wr_phase),
   .freq_words_o  (freq_words_o),
   .phase_words_o (phase_words_o),
   .autoclear_o   (autoclear_o),
   .clear_acc_o   (clear_acc_o)
);

// File: tb/test_chan_reg_bank.sv
`timescale 1ns/1ps
module test_chan_reg_bank;
   localparam int NCH = 4;
   localparam int FW  = 32;
   localparam int PW  = 14;

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, io_update = 1'b0;
   logic [NCH*FW-1:0] freq_w;
   logic [NCH*PW-1:0] phase_w;
   logic autoclr, clracc;

   always #2 clk = ~clk;

   chan_reg_bank i_chan_reg_bank (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .io_update(io_update), .freq_words_o(freq_w), .phase_words_o(phase_w),
      .autoclear_o(autoclr), .clear_acc_o(clracc)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   logic [31:0] m_af [NCH];
   logic [31:0] m_pf [NCH];
   logic [13:0] m_ap [NCH];
   logic [13:0] m_pp [NCH];
   logic [23:0] m_actl, m_pctl;
   logic [3:0]  m_en;
   logic        h1, h2, h3;

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_af[c] = '0; m_pf[c] = '0; m_ap[c] = '0; m_pp[c] = '0;
      end
      m_actl = '0; m_pctl = '0; m_en = 4'hF;
      h1 = 0; h2 = 0; h3 = 0;
   end

   // commit model: output moves at the third posedge after io_update rises (R6)
   always @(posedge clk) begin
      if (!rst_n) begin
         h1 = 0; h2 = 0; h3 = 0;
      end else begin
         if (h2 && !h3) begin
            for (int c = 0; c < NCH; c++) begin
               m_af[c] = m_pf[c];
               m_ap[c] = m_pp[c];
            end
            m_actl = m_pctl;
         end
         h3 = h2; h2 = h1; h1 = io_update;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ok = 1'b1;
         for (int c = 0; c < NCH; c++) begin
            if (freq_w[c*FW +: FW] !== m_af[c]) ok = 1'b0;
            if (phase_w[c*PW +: PW] !== m_ap[c]) ok = 1'b0;
         end
         if (autoclr !== m_actl[13] || clracc !== m_actl[12]) ok = 1'b0;
         chk(ok, "R6 per-cycle active state", freq_w[31:0], m_af[0]);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b [8], input int nbits);
      cs_n = 1'b0;
      idle(6);
      for (int i = 0; i < nbits; i++) begin
         mosi = b[i/8][7 - (i % 8)];
         idle(8);
         sck = 1'b1;
         idle(8);
         sck = 1'b0;
      end
      idle(6);
      cs_n = 1'b1;
      idle(8);
   endtask

   task automatic wr_chsel(input logic [7:0] v);
      logic [7:0] b [8] = '{8'h00, v, 0, 0, 0, 0, 0, 0};
      send(b, 16);
      m_en = v[7:4];
   endtask

   task automatic wr_freq(input logic [31:0] v, input bit extra);
      logic [7:0] b [8] = '{8'h04, v[31:24], v[23:16], v[15:8], v[7:0], 8'h99, 0, 0};
      send(b, extra ? 48 : 40);
      for (int c = 0; c < NCH; c++) if (m_en[c]) m_pf[c] = v;
   endtask

   task automatic wr_phase(input logic [15:0] v);
      logic [7:0] b [8] = '{8'h05, v[15:8], v[7:0], 0, 0, 0, 0, 0};
      send(b, 24);
      for (int c = 0; c < NCH; c++) if (m_en[c]) m_pp[c] = v[13:0];
   endtask

   task automatic wr_ctrl(input logic [23:0] v);
      logic [7:0] b [8] = '{8'h03, v[23:16], v[15:8], v[7:0], 0, 0, 0, 0};
      send(b, 32);
      m_pctl = v;
   endtask

   task automatic pulse_update();
      io_update = 1'b1;
      idle(4);
      io_update = 1'b0;
      idle(6);
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(3);
      // R1 reset state
      chk(freq_w === '0, "R1 freq reset", freq_w[31:0], 0);
      chk(phase_w === '0, "R1 phase reset", {18'd0, phase_w[13:0]}, 0);
      chk({autoclr, clracc} === 2'b00, "R1 ctrl reset", {30'd0, autoclr, clracc}, 0);

      // R5 reset mask reaches all channels; R6 no change before commit
      wr_freq(32'h1234_5678, 1'b0);
      chk(freq_w === '0, "R6 pending not active", freq_w[31:0], 0);
      io_update = 1'b1;
      idle(2);
      chk(freq_w[31:0] === 32'h0, "R6 latency two edges", freq_w[31:0], 0);
      idle(1);
      chk(freq_w[31:0] === 32'h1234_5678, "R6 latency three edges", freq_w[31:0], 32'h1234_5678);
      io_update = 1'b0;
      idle(6);
      for (int c = 0; c < NCH; c++)
         chk(freq_w[c*FW +: FW] === 32'h1234_5678, "R3 R5 broadcast freq", freq_w[c*FW +: FW], 32'h1234_5678);

      // R4 phase upper bits dropped, R5 single-channel selects
      wr_chsel(8'h10);
      wr_phase(16'hFABC);
      wr_chsel(8'h40);
      wr_phase(16'h1555);
      pulse_update();
      chk(phase_w[0 +: PW] === 14'h3ABC, "R4 phase low bits", {18'd0, phase_w[0 +: PW]}, 32'h3ABC);
      chk(phase_w[2*PW +: PW] === 14'h1555, "R5 ch2 phase", {18'd0, phase_w[2*PW +: PW]}, 32'h1555);
      chk(phase_w[1*PW +: PW] === 14'h0, "R5 ch1 untouched", {18'd0, phase_w[1*PW +: PW]}, 0);

      // R8 extra byte ignored, R5 two-channel mask
      wr_chsel(8'hA0);
      wr_freq(32'hDEAD_BEEF, 1'b1);
      pulse_update();
      chk(freq_w[1*FW +: FW] === 32'hDEAD_BEEF, "R8 extra byte ch1", freq_w[1*FW +: FW], 32'hDEAD_BEEF);
      chk(freq_w[3*FW +: FW] === 32'hDEAD_BEEF, "R8 extra byte ch3", freq_w[3*FW +: FW], 32'hDEAD_BEEF);
      chk(freq_w[0 +: FW] === 32'h1234_5678, "R5 ch0 masked", freq_w[0 +: FW], 32'h1234_5678);

      // R8 unknown address changes nothing
      begin
         logic [7:0] b [8] = '{8'h07, 8'h11, 8'h22, 8'h33, 8'h44, 0, 0, 0};
         send(b, 40);
      end
      pulse_update();
      chk(freq_w[1*FW +: FW] === 32'hDEAD_BEEF, "R8 unknown address", freq_w[1*FW +: FW], 32'hDEAD_BEEF);

      // R9 truncated frame discarded
      wr_chsel(8'hF0);
      begin
         logic [7:0] b [8] = '{8'h04, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 0, 0, 0};
         send(b, 28);
      end
      pulse_update();
      chk(freq_w[0 +: FW] === 32'h1234_5678, "R9 partial word dropped", freq_w[0 +: FW], 32'h1234_5678);

      // R7 control word buffered
      wr_ctrl(24'h003000);
      chk({autoclr, clracc} === 2'b00, "R7 ctrl pending", {30'd0, autoclr, clracc}, 0);
      pulse_update();
      chk({autoclr, clracc} === 2'b11, "R7 both bits", {30'd0, autoclr, clracc}, 3);
      wr_ctrl(24'h002000);
      pulse_update();
      chk({autoclr, clracc} === 2'b10, "R7 autoclear only", {30'd0, autoclr, clracc}, 2);

      // R6 held level does not re-commit
      io_update = 1'b1;
      idle(6);
      wr_freq(32'h0BAD_F00D, 1'b0);
      chk(freq_w[0 +: FW] === 32'h1234_5678, "R6 held update no commit", freq_w[0 +: FW], 32'h1234_5678);
      io_update = 1'b0;
      idle(6);
      pulse_update();
      chk(freq_w[2*FW +: FW] === 32'h0BAD_F00D, "R6 next edge commits", freq_w[2*FW +: FW], 32'h0BAD_F00D);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule